// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Condition Flags

This block is the arithmetic and logic core of a small accumulator processor. It takes the current accumulator, a second byte operand, the incoming carry flag and a three-bit operation code, and produces in the same cycle an 8-bit result, the four condition flags (zero, subtract, half-carry, carry) and an enable that tells the register file whether the result should be written back to the accumulator.

Eight operations are supported: plain and carry-including addition, plain and borrow-including subtraction, bitwise AND, XOR and OR, and a compare that computes the subtraction flags while keeping the accumulator intact. Every flag is produced directly from the operands in the same evaluation, so the flag outputs are always final; no deferred half-carry reconstruction is needed downstream. Operand selection, instruction decode and the register file sit outside the block.

Top module: `alu8_acc_unit`

## Requirements
- R1: The operation code `op_i` selects 0=add, 1=add with carry, 2=subtract, 3=subtract with borrow, 4=AND, 5=XOR, 6=OR, 7=compare; `res_o` is the low 8 bits of acc+opnd (+cy for 1), acc-opnd (-cy for 3, and also acc-opnd for 7), or the bitwise result.
- R2: `acc_we_o` is 0 when `op_i`=7 and 1 for every other code.
- R3: For codes 0 and 1 the carry flag is bit 8 of the 9-bit sum; for codes 2, 3 and 7 it is set exactly when acc < opnd + cin, where cin is `cy_i` for code 3 and 0 otherwise.
- R4: For codes 0 and 1 the half-carry flag is set when acc[3:0] + opnd[3:0] + cin exceeds 15 (cin is `cy_i` for code 1, else 0).
- R5: For codes 2, 3 and 7 the half-carry flag is set when acc[3:0] < opnd[3:0] + cin (cin is `cy_i` for code 3, else 0).
- R6: The subtract flag is 1 for codes 2, 3 and 7 and 0 for all others.
- R7: AND sets half-carry and clears carry; XOR and OR clear both half-carry and carry.
- R8: The zero flag is 1 exactly when `res_o` is 0x00, for every code.
- R9: Compare yields the same `res_o` and flags as subtract on the same inputs.
- R10: `cy_i` has no effect on any output for codes 0, 2, 4, 5, 6 and 7.
- R11: `flags_o` is {Z, N, H, C} at bits 3..0; `flag_byte_o` places Z at bit 7, N at 6, H at 5, C at 4, with bits 3..0 always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Second operand byte |
| cy_i | input | 1 | Incoming carry flag |
| op_i | input | 3 | Operation code |
| res_o | output | 8 | Operation result |
| flags_o | output | 4 | Flags {Z, N, H, C} |
| flag_byte_o | output | 8 | Flags in flag-register byte layout |
| acc_we_o | output | 1 | Accumulator write-back enable |

## Verification
The block is purely combinational, so every output is due in the same cycle as the inputs that produce it, with zero register stages on any path. The bench drives a new operand set on the falling clock edge and samples all outputs a few nanoseconds later, well before the next rising edge, so each comparison sees settled values for exactly the stimulus just applied. Pairs of stimuli (subtract versus compare, carry low versus carry high) are applied back to back and each result is captured before the next drive.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_AND = 3'd4,
    OP_XOR = 3'd5,
    OP_OR  = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } alu_flags_t;

  localparam int FLAG_CNT = 4;

  // Subtracting family: sub, sub-with-borrow, compare.
  function automatic logic op_is_sub(input logic [2:0] op);
    return (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
  endfunction

  // Operations that fold the incoming carry into the operand.
  function automatic logic op_uses_cy(input logic [2:0] op);
    return (op == OP_ADC) || (op == OP_SBC);
  endfunction

  function automatic logic op_is_logic(input logic [2:0] op);
    return (op == OP_AND) || (op == OP_XOR) || (op == OP_OR);
  endfunction

  // Nibble carry for addition: low nibbles plus carry-in exceed 15.
  function automatic logic nib_add_carry(input logic [3:0] a, input logic [3:0] b,
                                         input logic cin);
    logic [4:0] t;
    t = {1'b0, a} + {1'b0, b} + {4'b0, cin};
    return t[4];
  endfunction

  // Nibble borrow for subtraction: a < b + cin on five bits.
  function automatic logic nib_sub_borrow(input logic [3:0] a, input logic [3:0] b,
                                          input logic cin);
    logic [4:0] rhs;
    rhs = {1'b0, b} + {4'b0, cin};
    return ({1'b0, a} < rhs);
  endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] y_o,
  output logic         carry_o,
  output logic         half_o
);
  import alu8_pkg::*;

  localparam int NIB = 4;

  logic [W:0] sum_w;
  logic [W:0] dif_w;
  logic       half_add_w;
  logic       half_sub_w;

  always_comb begin
    sum_w = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    dif_w = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
  end

  assign half_add_w = nib_add_carry(a_i[NIB-1:0], b_i[NIB-1:0], cin_i);
  assign half_sub_w = nib_sub_borrow(a_i[NIB-1:0], b_i[NIB-1:0], cin_i);

  assign y_o     = sub_i ? dif_w[W-1:0] : sum_w[W-1:0];
  assign carry_o = sub_i ? dif_w[W]     : sum_w[W];
  assign half_o  = sub_i ? half_sub_w   : half_add_w;

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    case (sel_i)
      2'd0:    y_o = a_i & b_i;
      2'd1:    y_o = a_i ^ b_i;
      2'd2:    y_o = a_i | b_i;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/alu8_flag_pack.sv
module alu8_flag_pack #(
  parameter int W = 8
) (
  input  alu8_pkg::alu_flags_t fl_i,
  output logic [3:0]           nib_o,
  output logic [W-1:0]         byte_o
);
  localparam int LOW = W - 4;

  assign nib_o = {fl_i.z, fl_i.n, fl_i.h, fl_i.c};

  generate
    if (LOW > 0) begin : g_pad
      assign byte_o = {fl_i.z, fl_i.n, fl_i.h, fl_i.c, {LOW{1'b0}}};
    end else begin : g_nopad
      assign byte_o = {fl_i.z, fl_i.n, fl_i.h, fl_i.c};
    end
  endgenerate
endmodule

// File: rtl/alu8_acc_unit.sv
module alu8_acc_unit #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              cy_i,
  input  logic [2:0]        op_i,
  output logic [DATA_W-1:0] res_o,
  output logic [3:0]        flags_o,
  output logic [DATA_W-1:0] flag_byte_o,
  output logic              acc_we_o
);
  import alu8_pkg::*;

  // Named internal events, visible to the bound checker.
  logic              is_sub_w;
  logic              is_logic_w;
  logic              cin_w;
  logic [DATA_W-1:0] arith_y_w;
  logic              arith_c_w;
  logic              arith_h_w;
  logic [DATA_W-1:0] logic_y_w;
  alu_flags_t        fl_w;

  assign is_sub_w   = op_is_sub(op_i);
  assign is_logic_w = op_is_logic(op_i);
  assign cin_w      = op_uses_cy(op_i) & cy_i;

  alu8_arith #(.W(DATA_W)) u_arith (
    .a_i     (acc_i),
    .b_i     (opnd_i),
    .cin_i   (cin_w),
    .sub_i   (is_sub_w),
    .y_o     (arith_y_w),
    .carry_o (arith_c_w),
    .half_o  (arith_h_w)
  );

  alu8_bitwise #(.W(DATA_W)) u_bitwise (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .sel_i (op_i[1:0]),
    .y_o   (logic_y_w)
  );

  always_comb begin
    res_o = is_logic_w ? logic_y_w : arith_y_w;
    fl_w.z = (res_o == '0);
    fl_w.n = is_sub_w;
    if (is_logic_w) begin
      fl_w.h = (op_i == OP_AND);
      fl_w.c = 1'b0;
    end else begin
      fl_w.h = arith_h_w;
      fl_w.c = arith_c_w;
    end
  end

  assign acc_we_o = (op_i != OP_CMP);

  alu8_flag_pack #(.W(DATA_W)) u_pack (
    .fl_i   (fl_w),
    .nib_o  (flags_o),
    .byte_o (flag_byte_o)
  );

endmodule

// File: rtl/alu8_acc_checker.sv
module alu8_acc_checker #(
  parameter int DATA_W = 8
) (
  input logic [DATA_W-1:0] acc_i,
  input logic [DATA_W-1:0] opnd_i,
  input logic [2:0]        op_i,
  input logic              cin_w,
  input logic [DATA_W-1:0] res_o,
  input logic [3:0]        flags_o,
  input logic [DATA_W-1:0] flag_byte_o,
  input logic              acc_we_o
);
  logic [DATA_W:0] rhs_w;
  assign rhs_w = {1'b0, opnd_i} + {{DATA_W{1'b0}}, cin_w};

  always_comb begin
    a_r2_we_only_cmp: assert (acc_we_o == (op_i != 3'd7));
    a_r8_zero_tracks_result: assert (flags_o[3] == (res_o == '0));
    a_r6_sub_flag: assert (flags_o[2] == (op_i == 3'd2 || op_i == 3'd3 || op_i == 3'd7));
    if (op_i >= 3'd4 && op_i != 3'd7) begin
      a_r7_logic_no_carry: assert (flags_o[0] == 1'b0);
    end
    if (op_i == 3'd2 || op_i == 3'd3 || op_i == 3'd7) begin
      a_r3_borrow: assert (flags_o[0] == ({1'b0, acc_i} < rhs_w));
    end
    a_r11_byte_layout: assert (flag_byte_o == {flags_o, {(DATA_W-4){1'b0}}});
  end
endmodule

bind alu8_acc_unit alu8_acc_checker #(.DATA_W(DATA_W)) u_chk (
  .acc_i       (acc_i),
  .opnd_i      (opnd_i),
  .op_i        (op_i),
  .cin_w       (cin_w),
  .res_o       (res_o),
  .flags_o     (flags_o),
  .flag_byte_o (flag_byte_o),
  .acc_we_o    (acc_we_o)
);

// File: tb/tb_alu8_acc_unit.sv
module tb_alu8_acc_unit;
  logic       clk = 1'b0;
  logic [7:0] acc, opnd;
  logic       cy;
  logic [2:0] op;
  logic [7:0] res, fbyte;
  logic [3:0] fl;
  logic       we;
  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alu8_acc_unit dut (
    .acc_i(acc), .opnd_i(opnd), .cy_i(cy), .op_i(op),
    .res_o(res), .flags_o(fl), .flag_byte_o(fbyte), .acc_we_o(we)
  );

  task automatic chk(input string tag, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s op=%0d acc=%0h opnd=%0h cy=%0d: got %0h expected %0h",
               tag, op, acc, opnd, cy, got, exp);
    end
  endtask

  task automatic apply(input int o, input int a, input int b, input int c);
    @(negedge clk);
    op = 3'(o); acc = 8'(a); opnd = 8'(b); cy = 1'(c);
    #3;
  endtask

  // Independent reference model written from the requirements.
  task automatic verify();
    int a, b, o, ci, r, z, n, h, c;
    a = int'(acc); b = int'(opnd); o = int'(op);
    ci = 0; r = 0; h = 0; c = 0;
    case (o)
      0, 1: begin
        ci = (o == 1) ? int'(cy) : 0;
        r = a + b + ci;
        c = (r > 255) ? 1 : 0;
        h = ((a % 16) + (b % 16) + ci > 15) ? 1 : 0;
        r = r % 256;
      end
      2, 3, 7: begin
        ci = (o == 3) ? int'(cy) : 0;
        c = (a < b + ci) ? 1 : 0;
        h = ((a % 16) < (b % 16) + ci) ? 1 : 0;
        r = (a - b - ci + 512) % 256;
      end
      4: begin r = int'(acc & opnd); h = 1; end
      5: r = int'(acc ^ opnd);
      default: r = int'(acc | opnd);
    endcase
    z = (r == 0) ? 1 : 0;
    n = (o == 2 || o == 3 || o == 7) ? 1 : 0;
    chk("R1 result", int'(res), r);
    chk("R8 zero", int'(fl[3]), z);
    chk("R6 subtract", int'(fl[2]), n);
    if (o >= 4 && o <= 6) begin
      chk("R7 half", int'(fl[1]), h);
      chk("R7 carry", int'(fl[0]), c);
    end else if (n == 1) begin
      chk("R5 half", int'(fl[1]), h);
      chk("R3 carry", int'(fl[0]), c);
    end else begin
      chk("R4 half", int'(fl[1]), h);
      chk("R3 carry", int'(fl[0]), c);
    end
    chk("R2 write enable", int'(we), (o == 7) ? 0 : 1);
    chk("R11 byte", int'(fbyte), (z << 7) | (n << 6) | (h << 5) | (c << 4));
  endtask

  initial begin : watchdog
    #(20 * 200000);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r_sub, r_cmp, r0;
    logic [3:0] f_sub, f_cmp, f0;
    int unused_seed;
    acc = 0; opnd = 0; cy = 0; op = 0;
    unused_seed = $urandom(32'h1d2c3b4a);
    #5;
    // Initial state: add of zeros gives zero with only Z set.
    chk("R8 initial zero", int'(fl), 4'b1000);

    // Directed corners
    apply(0, 8'h0F, 8'h01, 0); verify();   // R4 nibble overflow
    apply(0, 8'hFF, 8'h01, 0); verify();   // R3 wrap to zero, Z/H/C
    apply(1, 8'h0F, 8'h00, 1); verify();   // R4 carry pushes nibble
    apply(1, 8'hFF, 8'h00, 1); verify();   // R3 carry from carry-in alone
    apply(3, 8'h10, 8'h00, 1); verify();   // R5 borrow-in creates H
    apply(3, 8'h00, 8'hFF, 1); verify();   // R3 borrow with cin
    apply(2, 8'h00, 8'h01, 0); verify();   // R3 plain borrow
    apply(7, 8'h42, 8'h42, 0); verify();   // R9 equal compare -> Z
    apply(4, 8'hF0, 8'h0F, 1); verify();   // R7 AND zero
    apply(5, 8'hAA, 8'hAA, 1); verify();   // R7 XOR zero
    apply(6, 8'h00, 8'h00, 0); verify();   // R7 OR zero

    // Random vectors
    for (int i = 0; i < 3000; i++) begin
      apply(int'($urandom_range(7, 0)), int'($urandom_range(255, 0)),
            int'($urandom_range(255, 0)), int'($urandom_range(1, 0)));
      verify();
    end

    // R9: compare matches subtract on the same inputs
    for (int i = 0; i < 200; i++) begin
      int a, b;
      a = int'($urandom_range(255, 0)); b = int'($urandom_range(255, 0));
      apply(2, a, b, 1); r_sub = res; f_sub = fl;
      apply(7, a, b, 1); r_cmp = res; f_cmp = fl;
      chk("R9 cmp result", int'(r_cmp), int'(r_sub));
      chk("R9 cmp flags", int'(f_cmp), int'(f_sub));
    end

    // R10: carry-in ignored outside codes 1 and 3
    for (int i = 0; i < 300; i++) begin
      int a, b, o;
      o = int'($urandom_range(5, 0));
      o = (o == 1) ? 7 : ((o == 3) ? 6 : o);
      a = int'($urandom_range(255, 0)); b = int'($urandom_range(255, 0));
      apply(o, a, b, 0); r0 = res; f0 = fl;
      apply(o, a, b, 1);
      chk("R10 cy ignored result", int'(res), int'(r0));
      chk("R10 cy ignored flags", int'(fl), int'(f0));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule